// File: doc/BRIEF.md
# DRAM refresh and initialization scheduler

This block keeps an asynchronous DRAM of 512 rows alive. After reset it holds off for a power-up pause. It then runs a fixed number of warm-up refresh cycles and raises `init_done`. From that point it issues one refresh at a steady interval, so that every row is refreshed well inside the retention period. All timing is given in nanoseconds as parameters and converted to clock cycles by rounding up.

The scheduler shares the memory bus with an access sequencer through a request/grant pair. It raises `ref_req` while it has refresh work. Once `ref_gnt` is high, it starts a cycle and drives the row strobe and both column strobes itself. `ref_drive` is high for as long as it owns the bus. The default cycle is the CAS-before-RAS form, in which the device's own row counter supplies the address. A parameter instead selects the RAS-only form, in which the scheduler drives a 9-bit row address from its own counter.

Refreshes that come due while the grant is withheld are counted in a bounded backlog. `ref_urgent` rises when the backlog is full.

Top module: `dram_refresh_sched`

## Requirements
- R1: While reset is asserted, the strobes `ras_n`, `ucas_n` and `lcas_n` are high (all strobes active low), `ref_req`, `init_done` and `ref_urgent` are low, and `row_addr` is zero.
- R2: `ref_req` first rises exactly PAUSE cycles after reset is released, and no strobe moves before that.
- R3: Exactly WARM_CNT refresh cycles run before `init_done` rises. They run back to back when the grant is held. `init_done` never falls again until reset.
- R4: In CAS-before-RAS mode, both column strobes fall together and stay low for the CAS setup cycles before `ras_n` falls. They rise exactly the CAS hold cycles after `ras_n` falls. `ucas_n` always equals `lcas_n`.
- R5: `ras_n` stays low for exactly the RAS pulse cycles in every refresh, never longer. Each refresh is framed by at least the RAS precharge cycles with all strobes high, both before and after it.
- R6: The strobes leave their high state only while `ref_gnt` is high. While the grant is withheld, no refresh starts and `ref_req` stays high when work is due.
- R7: After initialization, with the grant given on request, a refresh starts every INTERVAL cycles. Any window of 512 × INTERVAL cycles therefore holds 512 refreshes.
- R8: Refreshes that fall due without a grant are counted up to MAX_PEND, and `ref_urgent` is high while the count is at MAX_PEND. Once granted, pending refreshes run back to back, with one idle cycle plus one full refresh slot between starts, and `ref_urgent` drops once the backlog shrinks. `ref_urgent` is never high before `init_done`.
- R9: In RAS-only mode, both column strobes stay high. `row_addr` holds steady while `ras_n` is low and advances by one, wrapping from 511 to 0, after each refresh, warm-up cycles included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_req | output | 1 | Refresh work pending or in progress |
| ref_gnt | input | 1 | Bus granted by the access sequencer; held while `ref_drive` is high |
| ref_drive | output | 1 | Scheduler owns the strobes for a refresh cycle |
| init_done | output | 1 | Pause and warm-up sequence finished |
| ref_urgent | output | 1 | Backlog of postponed refreshes is full |
| ras_n | output | 1 | Row strobe, active low |
| ucas_n | output | 1 | Upper byte column strobe, active low |
| lcas_n | output | 1 | Lower byte column strobe, active low |
| row_addr | output | ROW_W | Row address for RAS-only refresh; zero in CAS-before-RAS mode |

## Verification
A wrong cycle counter in the strobe sequencer shows up at the pins on the first refresh after the pause. It appears as a RAS pulse of the wrong length or as CAS rising at the wrong point, measured edge to edge. A stuck or miscounted phase register shifts the first request or lets `init_done` rise after the wrong number of warm-up cycles, which is visible within a few hundred cycles of reset. Backlog errors show only once the grant is withheld. There they appear as a missing `ref_urgent` after several intervals, or as gaps between refreshes once the grant returns. A faulty interval timer changes the spacing of refreshes from the second interval onward.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_SETUP,
    ST_ACT,
    ST_POST
  } strobe_st_t;

  typedef enum logic [1:0] {
    PH_PAUSE,
    PH_WARM,
    PH_RUN
  } phase_t;

  // Nanoseconds to whole clock cycles, rounded up.
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ps);
    return (ns * 1000 + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // Bits needed to hold values 0 .. n-1.
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/dram_ref_timer.sv
module dram_ref_timer #(
  parameter int unsigned PERIOD = 3120
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int unsigned W = dram_ref_pkg::cnt_width(PERIOD);

  logic [W-1:0] cnt_q;

  assign tick = en && (cnt_q == W'(PERIOD - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || !en) cnt_q <= '0;
    else if (tick)     cnt_q <= '0;
    else               cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/dram_ref_backlog.sv
module dram_ref_backlog #(
  parameter int unsigned MAX_PEND = 8,
  parameter int unsigned PW       = dram_ref_pkg::cnt_width(MAX_PEND + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          due,
  input  logic          served,
  output logic [PW-1:0] count,
  output logic          urgent
);
  function automatic logic [PW-1:0] step(input logic [PW-1:0] c, input logic inc, input logic dec);
    if (inc && !dec) return (c == PW'(MAX_PEND)) ? c : c + 1'b1;
    if (dec && !inc) return (c == '0) ? c : c - 1'b1;
    return c;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else        count <= step(count, en && due, en && served);
  end

  assign urgent = (count == PW'(MAX_PEND));
endmodule

// File: rtl/dram_ref_strobe.sv
module dram_ref_strobe
  import dram_ref_pkg::*;
#(
  parameter int unsigned RAS_CYC  = 14,
  parameter int unsigned RP_CYC   = 10,
  parameter int unsigned CSR_CYC  = 2,
  parameter int unsigned CHR_CYC  = 2,
  parameter bit          CAS_LEAD = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done,
  output logic ras_n,
  output logic cas_n
);
  localparam int unsigned CW = cnt_width(max_of(RAS_CYC, max_of(RP_CYC, CSR_CYC)));

  strobe_st_t    st_q, st_d;
  logic [CW-1:0] cnt_q;
  logic          last;
  logic          ras_d, cas_d;

  always_comb begin
    case (st_q)
      ST_PRE, ST_POST: last = (cnt_q == CW'(RP_CYC - 1));
      ST_SETUP:        last = (cnt_q == CW'(CSR_CYC - 1));
      ST_ACT:          last = (cnt_q == CW'(RAS_CYC - 1));
      default:         last = 1'b0;
    endcase
  end

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:  if (start) st_d = ST_PRE;
      ST_PRE:   if (last)  st_d = ST_SETUP;
      ST_SETUP: if (last)  st_d = ST_ACT;
      ST_ACT:   if (last)  st_d = ST_POST;
      ST_POST:  if (last)  st_d = ST_IDLE;
      default:             st_d = ST_IDLE;
    endcase
  end

  assign ras_d = !(st_q == ST_ACT);

  generate
    if (CAS_LEAD) begin : g_cbr
      assign cas_d = !((st_q == ST_SETUP) || (st_q == ST_ACT && cnt_q < CW'(CHR_CYC)));
    end else begin : g_rasonly
      assign cas_d = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      ras_n <= 1'b1;
      cas_n <= 1'b1;
    end else begin
      st_q  <= st_d;
      cnt_q <= (last || st_q == ST_IDLE) ? '0 : cnt_q + 1'b1;
      ras_n <= ras_d;
      cas_n <= cas_d;
    end
  end

  assign busy = (st_q != ST_IDLE);
  assign done = (st_q == ST_POST) && last;
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import dram_ref_pkg::*;
#(
  parameter int unsigned CLK_PS      = 5000,
  parameter int unsigned PAUSE_NS    = 100000,
  parameter int unsigned INTERVAL_NS = 15600,
  parameter int unsigned T_RAS_NS    = 70,
  parameter int unsigned T_RP_NS     = 50,
  parameter int unsigned T_CSR_NS    = 10,
  parameter int unsigned T_CHR_NS    = 10,
  parameter int unsigned WARM_CNT    = 8,
  parameter int unsigned MAX_PEND    = 8,
  parameter int unsigned ROW_W       = 9,
  parameter bit          RAS_ONLY    = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic             ref_req,
  input  logic             ref_gnt,
  output logic             ref_drive,
  output logic             init_done,
  output logic             ref_urgent,
  output logic             ras_n,
  output logic             ucas_n,
  output logic             lcas_n,
  output logic [ROW_W-1:0] row_addr
);
  localparam int unsigned PAUSE_CYC = ns_to_cyc(PAUSE_NS, CLK_PS);
  localparam int unsigned IVL_CYC   = ns_to_cyc(INTERVAL_NS, CLK_PS);
  localparam int unsigned RAS_CYC   = ns_to_cyc(T_RAS_NS, CLK_PS);
  localparam int unsigned RP_CYC    = ns_to_cyc(T_RP_NS, CLK_PS);
  localparam int unsigned CSR_CYC   = ns_to_cyc(T_CSR_NS, CLK_PS);
  localparam int unsigned CHR_CYC   = ns_to_cyc(T_CHR_NS, CLK_PS);
  localparam int unsigned PAUSE_W   = cnt_width(PAUSE_CYC);
  localparam int unsigned WARM_W    = cnt_width(WARM_CNT + 1);
  localparam int unsigned PEND_W    = cnt_width(MAX_PEND + 1);

  phase_t             phase_q;
  logic [PAUSE_W-1:0] pause_q;
  logic [WARM_W-1:0]  warm_q;
  logic [PEND_W-1:0]  pend_cnt;
  logic               pause_end, warm_last, run_phase;
  logic               refresh_need, cyc_start, cyc_done, cyc_busy, tick;
  logic               cas_n;

  assign run_phase    = (phase_q == PH_RUN);
  assign pause_end    = (phase_q == PH_PAUSE) && (pause_q == PAUSE_W'(PAUSE_CYC - 1));
  assign warm_last    = (phase_q == PH_WARM) && cyc_done && (warm_q == WARM_W'(1));
  assign refresh_need = ((phase_q == PH_WARM) && (warm_q != '0)) ||
                        (run_phase && (pend_cnt != '0));
  assign cyc_start    = ref_gnt && refresh_need && !cyc_busy;
  assign ref_req      = refresh_need || cyc_busy;
  assign ref_drive    = cyc_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q   <= PH_PAUSE;
      pause_q   <= '0;
      warm_q    <= WARM_W'(WARM_CNT);
      init_done <= 1'b0;
    end else begin
      case (phase_q)
        PH_PAUSE: begin
          pause_q <= pause_q + 1'b1;
          if (pause_end) phase_q <= PH_WARM;
        end
        PH_WARM: begin
          if (cyc_done) warm_q <= warm_q - 1'b1;
          if (warm_last) begin
            phase_q   <= PH_RUN;
            init_done <= 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  dram_ref_timer #(.PERIOD(IVL_CYC)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (run_phase),
    .tick (tick)
  );

  dram_ref_backlog #(.MAX_PEND(MAX_PEND), .PW(PEND_W)) u_backlog (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (run_phase),
    .due   (tick),
    .served(cyc_done),
    .count (pend_cnt),
    .urgent(ref_urgent)
  );

  dram_ref_strobe #(
    .RAS_CYC (RAS_CYC),
    .RP_CYC  (RP_CYC),
    .CSR_CYC (CSR_CYC),
    .CHR_CYC (CHR_CYC),
    .CAS_LEAD(!RAS_ONLY)
  ) u_strobe (
    .clk  (clk),
    .rst_n(rst_n),
    .start(cyc_start),
    .busy (cyc_busy),
    .done (cyc_done),
    .ras_n(ras_n),
    .cas_n(cas_n)
  );

  assign ucas_n = cas_n;
  assign lcas_n = cas_n;

  generate
    if (RAS_ONLY) begin : g_row
      logic [ROW_W-1:0] row_q;
      always_ff @(posedge clk) begin
        if (!rst_n)        row_q <= '0;
        else if (cyc_done) row_q <= row_q + 1'b1;
      end
      assign row_addr = row_q;
    end else begin : g_norow
      assign row_addr = '0;
    end
  endgenerate
endmodule

// File: rtl/dram_refresh_sched_chk.sv
module dram_refresh_sched_chk #(
  parameter int unsigned RAS_CYC  = 14,
  parameter bit          RAS_ONLY = 1'b0,
  parameter int unsigned ROW_W    = 9,
  parameter int unsigned PEND_W   = 4,
  parameter int unsigned MAX_PEND = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ras_n,
  input logic             ucas_n,
  input logic             lcas_n,
  input logic             ref_gnt,
  input logic             init_done,
  input logic             ref_urgent,
  input logic [ROW_W-1:0] row_addr,
  input logic [PEND_W-1:0] pend_cnt
);
  localparam int unsigned RW = dram_ref_pkg::cnt_width(RAS_CYC + 2);

  logic [RW-1:0] ras_run;

  always_ff @(posedge clk) begin
    if (!rst_n)                         ras_run <= '0;
    else if (ras_n)                     ras_run <= '0;
    else if (ras_run != RW'(RAS_CYC + 1)) ras_run <= ras_run + 1'b1;
  end

  // R6
  strobe_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n || !ucas_n || !lcas_n) |-> ref_gnt);

  // R4
  lanes_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ucas_n == lcas_n);

  // R5
  ras_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ras_run <= RW'(RAS_CYC));

  // R5
  ras_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> (ras_run == RW'(RAS_CYC)));

  // R3
  init_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  // R8
  urgent_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> !ref_urgent);

  // R8
  pend_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_cnt <= PEND_W'(MAX_PEND));

  // R8
  pend_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_cnt > $past(pend_cnt)) |-> (pend_cnt == $past(pend_cnt) + 1'b1));

  generate
    if (RAS_ONLY) begin : g_ro
      // R9
      ro_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ucas_n && lcas_n);
      // R9
      ro_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n |-> $stable(row_addr));
    end else begin : g_cbr
      // R4
      cbr_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (!ucas_n && !$past(ucas_n)));
    end
  endgenerate
endmodule

bind dram_refresh_sched dram_refresh_sched_chk #(
  .RAS_CYC (RAS_CYC),
  .RAS_ONLY(RAS_ONLY),
  .ROW_W   (ROW_W),
  .PEND_W  (PEND_W),
  .MAX_PEND(MAX_PEND)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ras_n     (ras_n),
  .ucas_n    (ucas_n),
  .lcas_n    (lcas_n),
  .ref_gnt   (ref_gnt),
  .init_done (init_done),
  .ref_urgent(ref_urgent),
  .row_addr  (row_addr),
  .pend_cnt  (pend_cnt)
);

// File: tb/dram_refresh_sched_tb.sv
`timescale 1ns/1ps
module dram_refresh_sched_tb;
  // Expected timing restated in 5 ns cycles.
  localparam int PAUSE = 100;  // 500 ns pause
  localparam int IVL   = 60;   // 300 ns interval
  localparam int RAS   = 14;   // 70 ns
  localparam int RP    = 10;   // 50 ns
  localparam int CSR   = 2;    // 10 ns
  localparam int CHR   = 2;    // 10 ns
  localparam int WARM  = 8;
  localparam int MAXP  = 4;
  localparam int ROWS  = 512;
  localparam int SLOT  = 1 + RP + CSR + RAS + RP;

  logic clk = 1'b0, rst_n = 1'b0;
  logic gnt = 1'b0, gnt_ro = 1'b0, allow = 1'b1;
  logic req, drive, init_done, urgent, ras_n, ucas_n, lcas_n;
  logic [8:0] row;
  logic req_ro, drive_ro, init_ro, urg_ro, ras_ro, ucas_ro, lcas_ro;
  logic [8:0] row_ro;

  int     vectors = 0, fails = 0, ro_falls = 0;
  longint cyc = 0;
  bit     exp_init[$];
  int     exp_row[$];
  longint falls[$];

  dram_refresh_sched #(.PAUSE_NS(500), .INTERVAL_NS(300), .MAX_PEND(MAXP)) u_dut (
    .clk(clk), .rst_n(rst_n), .ref_req(req), .ref_gnt(gnt), .ref_drive(drive),
    .init_done(init_done), .ref_urgent(urgent), .ras_n(ras_n), .ucas_n(ucas_n),
    .lcas_n(lcas_n), .row_addr(row));

  dram_refresh_sched #(.PAUSE_NS(500), .INTERVAL_NS(300), .MAX_PEND(MAXP), .RAS_ONLY(1'b1)) u_dut_ro (
    .clk(clk), .rst_n(rst_n), .ref_req(req_ro), .ref_gnt(gnt_ro), .ref_drive(drive_ro),
    .init_done(init_ro), .ref_urgent(urg_ro), .ras_n(ras_ro), .ucas_n(ucas_ro),
    .lcas_n(lcas_ro), .row_addr(row_ro));

  initial forever #2.5 clk = ~clk;
  initial forever begin @(posedge clk); cyc = cyc + 1; end

  // Arbiter stand-in: grant on request, never revoked mid-cycle.
  initial forever begin
    @(negedge clk);
    gnt    = req & (allow | drive);
    gnt_ro = req_ro;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push_expected();
    for (int i = 0; i < WARM; i++) exp_init.push_back(1'b0);
    for (int i = 0; i < 2000; i++) exp_init.push_back(1'b1);
    for (int i = 0; i < 2000; i++) exp_row.push_back(i % ROWS);
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // Monitor for the CAS-before-RAS instance.
  initial begin
    bit pr, pc;
    int rlow, rhigh, clow;
    bit e;
    pr = 1; pc = 1; rlow = 0; rhigh = 0; clow = 0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (pr && !ras_n) begin
          falls.push_back(cyc);
          if (exp_init.size() == 0) chk(1'b0, "R3 unexpected refresh", 1, 0);
          else begin
            e = exp_init.pop_front();
            chk(init_done == e, "R3 init_done at refresh", init_done, e);
          end
          chk(!ucas_n && !lcas_n, "R4 CAS low at RAS fall", {ucas_n, lcas_n}, 0);
          chk(clow >= CSR, "R4 CAS lead before RAS", clow, CSR);
          chk(rhigh >= RP, "R5 precharge before cycle", rhigh, RP);
        end
        if (!pr && ras_n) chk(rlow == RAS, "R5 RAS low width", rlow, RAS);
        if (!ras_n && !pr && !pc && ucas_n) chk(rlow == CHR, "R4 CAS hold after RAS fall", rlow, CHR);
      end
      if (!ras_n) begin rlow = pr ? 1 : rlow + 1; rhigh = 0; end
      else rhigh++;
      if (!ucas_n) clow++; else clow = 0;
      pr = ras_n; pc = ucas_n;
    end
  end

  // Monitor for the RAS-only instance.
  initial begin
    bit pr;
    int e;
    pr = 1;
    forever begin
      @(negedge clk);
      if (rst_n && pr && !ras_ro) begin
        ro_falls++;
        chk(ucas_ro && lcas_ro, "R9 CAS high in RAS-only cycle", {ucas_ro, lcas_ro}, 3);
        if (exp_row.size() == 0) chk(1'b0, "R9 unexpected refresh", 1, 0);
        else begin
          e = exp_row.pop_front();
          chk(row_ro == 9'(e), "R9 row address", row_ro, e);
        end
      end
      pr = ras_ro;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R7 watchdog expired: actual=%0d expected=%0d", cyc, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int n, n0, nf, guard, cnt;
    longint t0;
    push_expected();
    step(3);
    // R1 reset state
    chk(ras_n && ucas_n && lcas_n, "R1 strobes high in reset", {ras_n, ucas_n, lcas_n}, 7);
    chk(!req, "R1 no request in reset", req, 0);
    chk(!init_done, "R1 init_done low in reset", init_done, 0);
    chk(!urgent, "R1 urgent low in reset", urgent, 0);
    chk(row_ro == 0, "R1 row zero in reset", row_ro, 0);
    rst_n = 1'b1;

    // R2 pause length
    n = 0;
    do begin
      step(1);
      n++;
      if (!ras_n || !ucas_n) chk(1'b0, "R2 strobe during pause", n, PAUSE);
    end while (!req && n < 4 * PAUSE);
    chk(n == PAUSE, "R2 first request after pause", n, PAUSE);

    // R3 warm-up
    guard = 0;
    while (!init_done && guard < 2000) begin step(1); guard++; end
    chk(falls.size() == WARM, "R3 warm-up count", falls.size(), WARM);
    if (falls.size() >= 2) chk(falls[1] - falls[0] == SLOT, "R3 warm-up back to back", falls[1] - falls[0], SLOT);

    // R7 steady spacing and 512 refreshes per window
    n0 = falls.size();
    guard = 0;
    while (falls.size() < n0 + 2 && guard < 4 * IVL) begin step(1); guard++; end
    if (falls.size() >= n0 + 2) begin
      t0 = falls[n0];
      chk(falls[n0 + 1] - falls[n0] == IVL, "R7 refresh spacing", falls[n0 + 1] - falls[n0], IVL);
      while (cyc < t0 + ROWS * IVL + 2) step(1);
      cnt = 0;
      foreach (falls[i]) if (falls[i] >= t0 && falls[i] < t0 + ROWS * IVL) cnt++;
      chk(cnt == ROWS, "R7 refreshes per window", cnt, ROWS);
    end else chk(1'b0, "R7 no steady refresh", falls.size(), n0 + 2);

    // R8 backlog under a withheld grant
    guard = 0;
    while ((req || drive) && guard < 4 * IVL) begin step(1); guard++; end
    chk(!urgent, "R8 urgent low in normal run", urgent, 0);
    allow = 1'b0;
    step(1);
    nf = falls.size();
    step((MAXP + 2) * IVL);
    chk(urgent, "R8 urgent at full backlog", urgent, 1);
    chk(falls.size() == nf, "R6 no refresh without grant", falls.size(), nf);
    chk(req, "R6 request held without grant", req, 1);
    chk(ras_n && ucas_n, "R6 strobes idle without grant", {ras_n, ucas_n}, 3);
    allow = 1'b1;
    guard = 0;
    while (falls.size() < nf + 2 && guard < 4 * SLOT) begin step(1); guard++; end
    if (falls.size() >= nf + 2)
      chk(falls[nf + 1] - falls[nf] == SLOT, "R8 backlog drained back to back", falls[nf + 1] - falls[nf], SLOT);
    else chk(1'b0, "R8 backlog not drained", falls.size(), nf + 2);
    step(600);
    chk(!urgent, "R8 urgent cleared after drain", urgent, 0);

    // R9 row counter wrapped
    chk(ro_falls > ROWS, "R9 row counter wrap reached", ro_falls, ROWS + 1);
    chk(row == 0, "R9 no row address in CAS-before-RAS mode", row, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule